// File: doc/BRIEF.md
# Vector-Triggered Privilege Domain Controller

This block keeps track of the process ID (the privilege domain) under which a CPU core is running. It watches the core's instruction-fetch address. When a valid fetch lands on one of seven programmable vector addresses whose enable bit is set, it forces the current ID to 0, the privileged domain. In the same edge it stores a snapshot of the interrupted context in a per-vector capture register. The snapshot holds the ID that was running and the previously detected vector index.

Software leaves the privileged domain in two steps. It first writes the target ID. It then writes a confirm register. The switch takes effect after a programmable number of cycles. A second programmable delay controls when a non-maskable-interrupt mask output drops after a release request. All configuration goes through a simple single-cycle register port whose read data is combinational.

The fetch port only observes the address stream. It has no ready signal and never applies back-pressure: every cycle where `fetch_valid` is high is a fetch that the block compares.

Top module: `vec_pid_ctrl`

## Requirements
- R1: After reset `cur_pid` is 0 and `nmi_mask` is 0. The switch delay (offset 0x20, 12 bits) reads 20 and the NMI delay (offset 0x24, 12 bits) reads 16. The enable register (0x00), every capture register and the last-vector register read 0.
- R2: A fetch with `fetch_valid` high whose address equals vector address n forces `cur_pid` to 0 at that clock edge. This applies only when enable bit n of offset 0x00 (bits 7:1) is set. Vector n's address is at offset 0x04·n. A disabled vector, or an address present while `fetch_valid` is low, leaves `cur_pid` unchanged.
- R3: On a hit of vector n, capture register n (offset 0x28+4·n) takes the ID that was running in bits [2:0]. It takes the last-vector register's previous contents in bits [6:3]. The last-vector register (0x28, 4 bits) then holds n.
- R4: When several enabled vectors match in the same cycle, the lowest index wins. Only its capture register and the last-vector value change.
- R5: Writing any value to the confirm register (0x4C) latches the ID held in the new-ID register (0x48, 3 bits). `cur_pid` takes that ID D edges after the write edge, where D is the switch delay. With D = 0 the new ID is visible in the cycle right after the write.
- R6: A vector hit while a switch is pending cancels the switch, and `cur_pid` stays 0.
- R7: A write to 0x54 raises `nmi_mask` at the write edge. A write to 0x58 lowers it D edges after the write edge, where D is the NMI delay. A write to 0x54 during that wait cancels the release.
- R8: Software can write the last-vector register. The written value becomes the level field of the next capture.
- R9: Reads of unmapped offsets, of the confirm register and of the NMI control offsets return 0. Writes to unmapped offsets change nothing. Bit 0 of the enable register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| cur_pid | output | 3 | Current process ID |
| nmi_mask | output | 1 | NMI mask |

## Verification
The assertions assume one register access per cycle. They also assume that inputs are stable around the rising edge and that `fetch_valid` is never X after reset. The bench drives every input on the falling edge, holds each strobe for exactly one cycle, and parks `fetch_valid` low between fetches. Random phases keep all vector addresses distinct. Address collisions appear only in the one directed test for the lowest-index rule, so the capture expectations stay unambiguous.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int NVEC  = 7;
  localparam int PID_W = 3;
  localparam int LVL_W = 4;

  localparam int OFS_EN      = 'h00;
  localparam int OFS_VEC0    = 'h00;  // vector n at OFS_VEC0 + 4*n
  localparam int OFS_SWDLY   = 'h20;
  localparam int OFS_NMIDLY  = 'h24;
  localparam int OFS_LAST    = 'h28;
  localparam int OFS_CAP0    = 'h28;  // capture n at OFS_CAP0 + 4*n
  localparam int OFS_NEWID   = 'h48;
  localparam int OFS_CONFIRM = 'h4C;
  localparam int OFS_NMI_SET = 'h54;
  localparam int OFS_NMI_REL = 'h58;
endpackage

// File: rtl/vpc_vector_match.sv
module vpc_vector_match #(
  parameter int NVEC   = 7,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [NVEC-1:0]   en,
  input  logic [ADDR_W-1:0] vaddr [NVEC],
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [NVEC-1:0]   grant
);
  logic [NVEC-1:0] raw;
  logic [NVEC:0]   below;

  assign below[0] = 1'b0;
  for (genvar i = 0; i < NVEC; i++) begin : g_cmp
    assign raw[i]     = fetch_valid && en[i] && (fetch_addr == vaddr[i]);
    assign below[i+1] = below[i] | raw[i];
    assign grant[i]   = raw[i] & ~below[i];
  end

  assign hit = below[NVEC];

  always_comb begin
    hit_idx = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (raw[i]) hit_idx = IDX_W'(i + 1);
    end
  end

  // R4: at most one winner, and a winner exists whenever anything matched
  assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($countones(grant) == 1));
endmodule

// File: rtl/vpc_delay_timer.sv
module vpc_delay_timer #(
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DLY_W-1:0] delay,
  input  logic             cancel,
  output logic             fire,
  output logic             busy
);
  logic [DLY_W-1:0] cnt;

  assign fire = !cancel && ((start && delay == '0) ||
                            (!start && busy && cnt == DLY_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (cancel) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= (delay != '0);
      cnt  <= delay;
    end else if (busy) begin
      if (cnt == DLY_W'(1)) busy <= 1'b0;
      cnt <= cnt - DLY_W'(1);
    end
  end

  // R5: a fired switch leaves nothing pending
  assert_fire_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !busy);
  // R6: cancellation drops any pending switch
  assert_cancel_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !busy);
endmodule

// File: rtl/vec_pid_ctrl.sv
module vec_pid_ctrl
  import vpc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int OFS_W       = 8,
  parameter int DLY_W       = 12,
  parameter int SW_DLY_RST  = 20,
  parameter int NMI_DLY_RST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [PID_W-1:0]  cur_pid,
  output logic              nmi_mask
);
  localparam int CAP_W = PID_W + LVL_W;

  logic [NVEC:1]      en_r;
  logic [ADDR_W-1:0]  vaddr_r [NVEC];
  logic [CAP_W-1:0]   cap_r   [NVEC];
  logic [DLY_W-1:0]   sw_dly_r, nmi_dly_r;
  logic [LVL_W-1:0]   last_r;
  logic [PID_W-1:0]   new_id_r, target_r;

  logic wr_en, wr_swdly, wr_nmidly, wr_last, wr_newid, wr_confirm, wr_nset, wr_nrel;
  logic [NVEC-1:0] wr_vec;

  assign wr_en      = reg_wr && reg_addr == OFS_W'(OFS_EN);
  assign wr_swdly   = reg_wr && reg_addr == OFS_W'(OFS_SWDLY);
  assign wr_nmidly  = reg_wr && reg_addr == OFS_W'(OFS_NMIDLY);
  assign wr_last    = reg_wr && reg_addr == OFS_W'(OFS_LAST);
  assign wr_newid   = reg_wr && reg_addr == OFS_W'(OFS_NEWID);
  assign wr_confirm = reg_wr && reg_addr == OFS_W'(OFS_CONFIRM);
  assign wr_nset    = reg_wr && reg_addr == OFS_W'(OFS_NMI_SET);
  assign wr_nrel    = reg_wr && reg_addr == OFS_W'(OFS_NMI_REL);

  for (genvar i = 0; i < NVEC; i++) begin : g_vdec
    assign wr_vec[i] = reg_wr && reg_addr == OFS_W'(OFS_VEC0 + 4 * (i + 1));
  end

  // vector comparison
  logic             hit;
  logic [LVL_W-1:0] hit_idx;
  logic [NVEC-1:0]  grant;

  vpc_vector_match #(.NVEC(NVEC), .ADDR_W(ADDR_W), .IDX_W(LVL_W)) u_match (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .en(en_r), .vaddr(vaddr_r), .hit(hit), .hit_idx(hit_idx), .grant(grant)
  );

  // deferred switch and NMI release timers
  logic pid_fire, pid_busy, nmi_fire, nmi_busy;

  vpc_delay_timer #(.DLY_W(DLY_W)) u_pid_tmr (
    .clk(clk), .rst_n(rst_n), .start(wr_confirm), .delay(sw_dly_r),
    .cancel(hit), .fire(pid_fire), .busy(pid_busy)
  );

  vpc_delay_timer #(.DLY_W(DLY_W)) u_nmi_tmr (
    .clk(clk), .rst_n(rst_n), .start(wr_nrel), .delay(nmi_dly_r),
    .cancel(wr_nset), .fire(nmi_fire), .busy(nmi_busy)
  );

  logic [PID_W-1:0] switch_to;
  assign switch_to = wr_confirm ? new_id_r : target_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r      <= '0;
      sw_dly_r  <= DLY_W'(SW_DLY_RST);
      nmi_dly_r <= DLY_W'(NMI_DLY_RST);
      last_r    <= '0;
      new_id_r  <= '0;
      target_r  <= '0;
      cur_pid   <= '0;
      nmi_mask  <= 1'b0;
      for (int i = 0; i < NVEC; i++) begin
        vaddr_r[i] <= '0;
        cap_r[i]   <= '0;
      end
    end else begin
      if (wr_en)      en_r      <= reg_wdata[NVEC:1];
      if (wr_swdly)   sw_dly_r  <= reg_wdata[DLY_W-1:0];
      if (wr_nmidly)  nmi_dly_r <= reg_wdata[DLY_W-1:0];
      if (wr_newid)   new_id_r  <= reg_wdata[PID_W-1:0];
      if (wr_confirm) target_r  <= new_id_r;
      for (int i = 0; i < NVEC; i++) begin
        if (wr_vec[i]) vaddr_r[i] <= reg_wdata[ADDR_W-1:0];
        if (grant[i])  cap_r[i]   <= {last_r, cur_pid};
      end
      if (hit)          last_r <= hit_idx;
      else if (wr_last) last_r <= reg_wdata[LVL_W-1:0];
      if (hit)           cur_pid <= '0;
      else if (pid_fire) cur_pid <= switch_to;
      if (wr_nset)       nmi_mask <= 1'b1;
      else if (nmi_fire) nmi_mask <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_W'(OFS_EN))     reg_rdata[NVEC:1]   = en_r;
    if (reg_addr == OFS_W'(OFS_SWDLY))  reg_rdata[DLY_W-1:0] = sw_dly_r;
    if (reg_addr == OFS_W'(OFS_NMIDLY)) reg_rdata[DLY_W-1:0] = nmi_dly_r;
    if (reg_addr == OFS_W'(OFS_LAST))   reg_rdata[LVL_W-1:0] = last_r;
    if (reg_addr == OFS_W'(OFS_NEWID))  reg_rdata[PID_W-1:0] = new_id_r;
    for (int i = 0; i < NVEC; i++) begin
      if (reg_addr == OFS_W'(OFS_VEC0 + 4 * (i + 1))) reg_rdata = DATA_W'(vaddr_r[i]);
      if (reg_addr == OFS_W'(OFS_CAP0 + 4 * (i + 1))) reg_rdata = DATA_W'(cap_r[i]);
    end
  end

  // R2: a hit puts the core in the privileged domain
  assert_hit_priv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cur_pid == '0);
  // R3: last-vector register follows the winning index
  assert_last_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> last_r == $past(hit_idx));
  // R5: the ID moves only on a hit or a fired switch
  assert_pid_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !pid_fire) |=> $stable(cur_pid));
  // R7: set request raises the mask
  assert_nmi_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_nset |=> nmi_mask);
  // R7: the mask falls only when the release timer fires
  assert_nmi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_mask && !nmi_fire) |=> nmi_mask);
endmodule

// File: tb/vec_pid_ctrl_bench.sv
module vec_pid_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic [2:0]  cur_pid;
  logic        nmi_mask;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  vec_pid_ctrl u_vec_pid_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .cur_pid(cur_pid), .nmi_mask(nmi_mask)
  );

  function automatic logic [7:0] vec_ofs(int n);  return 8'(4 * n);        endfunction
  function automatic logic [7:0] cap_ofs(int n);  return 8'('h28 + 4 * n); endfunction
  function automatic logic [31:0] vec_adr(int n); return 32'h4000_0000 + 32'(n * 'h40); endfunction
  function automatic logic [31:0] cap_val(int lvl, int pid);
    return 32'((lvl & 15) * 8 + (pid & 7));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic fetch(logic v, logic [31:0] a);
    fetch_valid = v; fetch_addr = a;
    @(posedge clk); @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // confirm a switch and check its exact timing
  task automatic switch_pid(string req, int id, int dly, logic [2:0] old);
    wr(8'h48, 32'(id));
    wr(8'h4C, 32'h0);
    for (int i = 0; i < dly; i++) begin
      check(req, 32'(cur_pid), 32'(old));
      @(negedge clk);
    end
    check(req, 32'(cur_pid), 32'(id));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int lastm, p, dl, nv;
    void'($urandom(32'd2024));
    idle(2); rst_n = 1'b1; idle(1);

    // R1 reset state
    check("R1 pid", 32'(cur_pid), 0);
    check("R1 nmi", 32'(nmi_mask), 0);
    rd(8'h20, d); check("R1 swdly", d, 20);
    rd(8'h24, d); check("R1 nmidly", d, 16);
    rd(8'h00, d); check("R1 enable", d, 0);
    rd(cap_ofs(1), d); check("R1 cap1", d, 0);
    rd(8'h28, d); check("R1 last", d, 0);

    // R9 unmapped and write-only offsets
    wr(8'h00, 32'hFF); rd(8'h00, d); check("R9 en bit0", d, 32'hFE);
    wr(8'h50, 32'hFFFF_FFFF); wr(8'h7C, 32'h1234);
    rd(8'h50, d); check("R9 unmapped rd", d, 0);
    rd(8'h20, d); check("R9 unmapped wr", d, 20);
    rd(8'h4C, d); check("R9 confirm rd", d, 0);
    check("R9 pid untouched", 32'(cur_pid), 0);

    for (int n = 1; n <= 7; n++) wr(vec_ofs(n), vec_adr(n));
    rd(vec_ofs(7), d); check("R2 vec7 addr", d, vec_adr(7));

    // R5 default delay, then short delay
    switch_pid("R5 dly20", 6, 20, 3'd0);
    wr(8'h20, 3);
    switch_pid("R5 dly3", 5, 3, 3'd6);

    // R2/R3 first hit
    fetch(1'b1, vec_adr(3));
    check("R2 hit", 32'(cur_pid), 0);
    rd(cap_ofs(3), d); check("R3 cap3", d, cap_val(0, 5));
    rd(8'h28, d); check("R3 last", d, 3);

    // R5 zero delay, R3 second hit
    wr(8'h20, 0);
    switch_pid("R5 dly0", 2, 0, 3'd0);
    fetch(1'b1, vec_adr(6));
    rd(cap_ofs(6), d); check("R3 cap6", d, cap_val(3, 2));

    // R2 disabled vector and invalid fetch
    wr(8'h00, 32'hBE);
    switch_pid("R5 to4", 4, 0, 3'd0);
    fetch(1'b1, vec_adr(6));
    check("R2 disabled", 32'(cur_pid), 4);
    fetch(1'b0, vec_adr(1));
    check("R2 not valid", 32'(cur_pid), 4);
    rd(8'h28, d); check("R2 last kept", d, 6);

    // R4 collision: vectors 2 and 5 share an address
    wr(8'h00, 32'hFE);
    wr(vec_ofs(2), vec_adr(5));
    fetch(1'b1, vec_adr(5));
    rd(8'h28, d); check("R4 last", d, 2);
    rd(cap_ofs(2), d); check("R4 cap2", d, cap_val(6, 4));
    rd(cap_ofs(5), d); check("R4 cap5", d, 0);
    wr(vec_ofs(2), vec_adr(2));

    // R6 hit cancels a pending switch
    switch_pid("R5 to7", 7, 0, 3'd0);
    wr(8'h20, 10); wr(8'h48, 1); wr(8'h4C, 0);
    idle(3);
    fetch(1'b1, vec_adr(1));
    idle(15);
    check("R6 cancelled", 32'(cur_pid), 0);
    rd(cap_ofs(1), d); check("R6 cap1", d, cap_val(2, 7));

    // R8 software-written last level
    wr(8'h28, 9); rd(8'h28, d); check("R8 last wr", d, 9);
    fetch(1'b1, vec_adr(4));
    rd(cap_ofs(4), d); check("R8 cap4", d, cap_val(9, 0));
    lastm = 4;

    // R7 NMI mask
    wr(8'h24, 5);
    wr(8'h54, 0); check("R7 set", 32'(nmi_mask), 1);
    wr(8'h58, 0);
    for (int i = 0; i < 5; i++) begin
      check("R7 hold", 32'(nmi_mask), 1); @(negedge clk);
    end
    check("R7 release", 32'(nmi_mask), 0);
    wr(8'h54, 0); wr(8'h58, 0); idle(2); wr(8'h54, 0); idle(10);
    check("R7 release cancelled", 32'(nmi_mask), 1);
    wr(8'h24, 0); wr(8'h58, 0);
    check("R7 dly0", 32'(nmi_mask), 0);

    // random phase: switch then hit
    for (int it = 0; it < 40; it++) begin
      p  = 1 + int'($urandom_range(6));
      dl = int'($urandom_range(5));
      nv = 1 + int'($urandom_range(6));
      wr(8'h20, 32'(dl));
      switch_pid("R5 rand", p, dl, 3'd0);
      if ($urandom_range(3) == 0) begin
        fetch(1'b0, vec_adr(nv));
        check("R2 rand invalid", 32'(cur_pid), 32'(p));
      end
      fetch(1'b1, vec_adr(nv));
      check("R2 rand hit", 32'(cur_pid), 0);
      rd(cap_ofs(nv), d); check("R3 rand cap", d, cap_val(lastm, p));
      lastm = nv;
      rd(8'h28, d); check("R3 rand last", d, 32'(nv));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule